// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side sequencer for a six-channel simultaneous-sampling converter that is read through a serial port. When a conversion is requested, it drives the three conversion-start lines together and then follows the converter's busy line. Once busy drops, it opens a readout frame by pulling frame-sync low. It then runs a divided serial clock and shifts in 16-bit results on one lane or on two lanes. During the same frame it shifts a 32-bit setup word out on the serial input line of the converter.

The channels are named A0, A1, B0, B1, C0 and C1. In dual-lane mode the frame is half as long as in single-lane mode. In that mode, the first lane returns pair A followed by C0, and the second lane returns pair B followed by C1. After the final bit, all six results appear together on a wide output bus, along with a one-cycle valid strobe. A sleep input puts the converter in standby. When sleep is released, conversion requests are held back until a settling interval has run out. Requests that arrive while a conversion or frame is already in flight are dropped and recorded in a sticky flag.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is held and directly after it, `adc_fs` and `adc_sclk` are 1 and `adc_convst`, `result_valid`, `overrun` and `result` are 0. `adc_stby_n` is 1 while `sleep` is 0.
- R2: A request accepted while idle drives all three `adc_convst` lines to 1 together for exactly PULSE_CYC clock cycles. The lines are never unequal.
- R3: After the start pulse, the controller waits for `adc_busy` to be seen at 1 and then at 0. Only then does `adc_fs` fall. No start pulse is issued while `adc_fs` is 0.
- R4: With `two_lane`=1, a frame has 48 serial clocks. Each half period lasts DIV clock cycles and `adc_sclk` idles at 1. The MSB is present when `adc_fs` falls, and the controller samples on each `adc_sclk` falling edge. `adc_sdo_a` carries A0, A1, C0 and `adc_sdo_b` carries B0, B1, C1, each word MSB first.
- R5: With `two_lane`=0, a frame has 96 serial clocks. `adc_sdo_a` carries A0, A1, B0, B1, C0, C1, in that order, each word MSB first.
- R6: `adc_sdi` sends the 32-bit setup word MSB first. Bit 31 is driven when `adc_fs` falls, each later bit changes on an `adc_sclk` rising edge, and the converter reads each bit on the following falling edge.
- R7: If bit 11 (external conversion clock) of `cfg_word` is 0, bit 23 (sequential mode) is sent as 0. In every other case the word is sent unchanged.
- R8: `result` holds channel k in bits [16k+15:16k], where k is 0..5 for A0, A1, B0, B1, C0, C1. It changes only in the cycle in which `result_valid` is 1. That pulse lasts one cycle and follows the final bit of the frame.
- R9: A `start_req` seen while a conversion or frame is in progress starts no extra conversion. It sets `overrun`, and only reset clears that flag.
- R10: `sleep`=1 drives `adc_stby_n` to 0. After `sleep` falls, start pulses are withheld for at least SETTLE_CYC cycles. Requests made during sleep or settling are then served by exactly one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_req | input | 1 | Conversion request |
| two_lane | input | 1 | 1 = two data lanes, 0 = one lane |
| cfg_word | input | 32 | Setup word sent on the serial input each frame |
| sleep | input | 1 | 1 = hold converter in standby |
| adc_convst | output | 3 | Conversion-start lines of the three pairs |
| adc_busy | input | 1 | Converter busy indication |
| adc_stby_n | output | 1 | Standby control, low = standby |
| adc_fs | output | 1 | Frame sync, low during a frame |
| adc_sclk | output | 1 | Serial clock |
| adc_sdi | output | 1 | Serial setup data to converter |
| adc_sdo_a | input | 1 | First serial data lane |
| adc_sdo_b | input | 1 | Second serial data lane |
| result | output | 96 | Six results, channel k at [16k+15:16k] |
| result_valid | output | 1 | One-cycle strobe for new results |
| overrun | output | 1 | Sticky flag for dropped requests |

## Verification
A fresh request can coincide with the phase in which the controller is waiting for busy to drop. In that case the refusal path and the conversion path act in the same cycle. The bench provokes this by pulsing `start_req` shortly after the start pulse ends. It then judges that `overrun` rises, that the converter model counts only one start pulse, and that the frame still returns the correct words. A second collision pits a request made during sleep against a request made during settling. Both must merge into a single conversion, and that conversion must come only after the interval.

// File: rtl/adc_serial_reader_pkg.sv
package adc_serial_reader_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_PULSE, ST_WAIT_HI, ST_WAIT_LO, ST_FRAME
   } rd_state_t;

   localparam int unsigned SETUP_W     = 32;
   localparam int unsigned EXTCLK_BIT  = 11;
   localparam int unsigned SEQ_BIT     = 23;

   // sequential mode is only legal together with the external clock bit
   function automatic logic [SETUP_W-1:0] legal_setup(input logic [SETUP_W-1:0] w);
      logic [SETUP_W-1:0] r;
      r = w;
      if (!w[EXTCLK_BIT]) r[SEQ_BIT] = 1'b0;
      return r;
   endfunction
endpackage

// File: rtl/adcrd_settle.sv
module adcrd_settle #(
   parameter int unsigned SETTLE_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   output logic ready
);
   localparam int unsigned CW = $clog2(SETTLE_CYC + 2);

   logic          sleep_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         sleep_q <= sleep;
         if (sleep_q && !sleep)  cnt_q <= CW'(SETTLE_CYC);
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready = !sleep && !sleep_q && (cnt_q == '0);
endmodule

// File: rtl/adcrd_frame.sv
module adcrd_frame #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned N_CH   = 6,
   parameter int unsigned DIV    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         two_lane,
   input  logic [31:0]                  setup,
   input  logic                         sdo_a,
   input  logic                         sdo_b,
   output logic                         fs,
   output logic                         sclk,
   output logic                         sdi,
   output logic                         done,
   output logic [N_CH*WORD_W-1:0]       lane_a,
   output logic [N_CH*WORD_W/2-1:0]     lane_b
);
   localparam int unsigned LONG  = N_CH * WORD_W;
   localparam int unsigned SHORT = LONG / 2;
   localparam int unsigned BCW   = $clog2(LONG + 1);
   localparam int unsigned DCW   = (DIV > 1) ? $clog2(DIV) : 1;

   logic            active_q, fs_q, sclk_q, sdi_q, done_q;
   logic [DCW-1:0]  div_q;
   logic [BCW-1:0]  bit_q;
   logic [31:0]     setup_q;
   logic [LONG-1:0] sh_a_q;
   logic [SHORT-1:0] sh_b_q;
   logic [BCW-1:0]  nbits;

   assign nbits = two_lane ? BCW'(SHORT) : BCW'(LONG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         fs_q     <= 1'b1;
         sclk_q   <= 1'b1;
         sdi_q    <= 1'b0;
         done_q   <= 1'b0;
         div_q    <= '0;
         bit_q    <= '0;
         setup_q  <= '0;
         sh_a_q   <= '0;
         sh_b_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!active_q) begin
            if (start) begin
               active_q <= 1'b1;
               fs_q     <= 1'b0;
               sclk_q   <= 1'b1;
               sdi_q    <= setup[31];
               setup_q  <= {setup[30:0], 1'b0};
               div_q    <= DCW'(DIV - 1);
               bit_q    <= '0;
            end
         end else if (div_q != '0) begin
            div_q <= div_q - 1'b1;
         end else begin
            div_q <= DCW'(DIV - 1);
            if (sclk_q) begin
               sclk_q <= 1'b0;
               sh_a_q <= {sh_a_q[LONG-2:0], sdo_a};
               sh_b_q <= {sh_b_q[SHORT-2:0], sdo_b};
               bit_q  <= bit_q + 1'b1;
            end else begin
               sclk_q <= 1'b1;
               if (bit_q == nbits) begin
                  active_q <= 1'b0;
                  fs_q     <= 1'b1;
                  sdi_q    <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  sdi_q   <= setup_q[31];
                  setup_q <= {setup_q[30:0], 1'b0};
               end
            end
         end
      end
   end

   assign fs     = fs_q;
   assign sclk   = sclk_q;
   assign sdi    = sdi_q;
   assign done   = done_q;
   assign lane_a = sh_a_q;
   assign lane_b = sh_b_q;
endmodule

// File: rtl/adcrd_unpack.sv
module adcrd_unpack #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned N_CH   = 6
) (
   input  logic                      two_lane,
   input  logic [N_CH*WORD_W-1:0]    lane_a,
   input  logic [N_CH*WORD_W/2-1:0]  lane_b,
   output logic [N_CH*WORD_W-1:0]    words
);
   localparam int unsigned LONG  = N_CH * WORD_W;
   localparam int unsigned SHORT = LONG / 2;

   if (N_CH != 6) begin : g_bad_nch
      $error("adcrd_unpack supports exactly six channels");
   end

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      // dual-lane placement: A0 A1 C0 on lane a, B0 B1 C1 on lane b
      localparam bit          ON_B = (k == 2) || (k == 3) || (k == 5);
      localparam int unsigned SLOT = (k < 2) ? k : ((k < 4) ? k - 2 : 2);
      logic [WORD_W-1:0] dual_w;
      if (ON_B) begin : g_b
         assign dual_w = lane_b[SHORT-1-SLOT*WORD_W -: WORD_W];
      end else begin : g_a
         assign dual_w = lane_a[SHORT-1-SLOT*WORD_W -: WORD_W];
      end
      assign words[k*WORD_W +: WORD_W] =
         two_lane ? dual_w : lane_a[LONG-1-k*WORD_W -: WORD_W];
   end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
   import adc_serial_reader_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned N_CH       = 6,
   parameter int unsigned DIV        = 2,
   parameter int unsigned PULSE_CYC  = 3,
   parameter int unsigned SETTLE_CYC = 1000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_req,
   input  logic                    two_lane,
   input  logic [31:0]             cfg_word,
   input  logic                    sleep,
   output logic [2:0]              adc_convst,
   input  logic                    adc_busy,
   output logic                    adc_stby_n,
   output logic                    adc_fs,
   output logic                    adc_sclk,
   output logic                    adc_sdi,
   input  logic                    adc_sdo_a,
   input  logic                    adc_sdo_b,
   output logic [N_CH*WORD_W-1:0]  result,
   output logic                    result_valid,
   output logic                    overrun
);
   localparam int unsigned PCW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("DIV must be at least 1");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("PULSE_CYC must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end

   rd_state_t                st_q;
   logic [PCW-1:0]           pcnt_q;
   logic                     conv_q, pend_q, lane_q, ovr_q, valid_q;
   logic [N_CH*WORD_W-1:0]   res_q;
   logic                     ready, frame_start, frame_done;
   logic [N_CH*WORD_W-1:0]   lane_a, words;
   logic [N_CH*WORD_W/2-1:0] lane_b;

   adcrd_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .ready(ready)
   );

   assign frame_start = (st_q == ST_WAIT_LO) && !adc_busy;

   adcrd_frame #(.WORD_W(WORD_W), .N_CH(N_CH), .DIV(DIV)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(frame_start), .two_lane(lane_q),
      .setup(legal_setup(cfg_word)), .sdo_a(adc_sdo_a), .sdo_b(adc_sdo_b),
      .fs(adc_fs), .sclk(adc_sclk), .sdi(adc_sdi), .done(frame_done),
      .lane_a(lane_a), .lane_b(lane_b)
   );

   adcrd_unpack #(.WORD_W(WORD_W), .N_CH(N_CH)) u_unpack (
      .two_lane(lane_q), .lane_a(lane_a), .lane_b(lane_b), .words(words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pcnt_q  <= '0;
         conv_q  <= 1'b0;
         pend_q  <= 1'b0;
         lane_q  <= 1'b0;
         ovr_q   <= 1'b0;
         valid_q <= 1'b0;
         res_q   <= '0;
      end else begin
         valid_q <= frame_done;
         if (frame_done) res_q <= words;
         if (start_req && st_q != ST_IDLE) ovr_q <= 1'b1;
         unique case (st_q)
            ST_IDLE: begin
               if ((start_req || pend_q) && ready) begin
                  st_q   <= ST_PULSE;
                  pend_q <= 1'b0;
                  conv_q <= 1'b1;
                  pcnt_q <= PCW'(PULSE_CYC - 1);
                  lane_q <= two_lane;
               end else if (start_req) begin
                  pend_q <= 1'b1;
               end
            end
            ST_PULSE: begin
               if (pcnt_q == '0) begin
                  conv_q <= 1'b0;
                  st_q   <= ST_WAIT_HI;
               end else begin
                  pcnt_q <= pcnt_q - 1'b1;
               end
            end
            ST_WAIT_HI: if (adc_busy) st_q <= ST_WAIT_LO;
            ST_WAIT_LO: if (!adc_busy) st_q <= ST_FRAME;
            ST_FRAME:   if (frame_done) st_q <= ST_IDLE;
            default:    st_q <= ST_IDLE;
         endcase
      end
   end

   assign adc_convst   = {3{conv_q}};
   assign adc_stby_n   = !sleep;
   assign result       = res_q;
   assign result_valid = valid_q;
   assign overrun      = ovr_q;
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
   parameter int unsigned RW = 96
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    adc_convst,
   input logic          adc_busy,
   input logic          adc_fs,
   input logic          adc_stby_n,
   input logic [RW-1:0] result,
   input logic          result_valid,
   input logic          overrun
);
   assert_lines_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_convst != 3'b000) |-> (adc_convst == 3'b111));

   assert_no_start_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_fs |-> (adc_convst == 3'b000));

   assert_frame_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_fs) |-> !adc_busy);

   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> result_valid);

   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   assert_start_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_convst[0]) |-> adc_stby_n);
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.RW(N_CH*WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_convst(adc_convst), .adc_busy(adc_busy),
   .adc_fs(adc_fs), .adc_stby_n(adc_stby_n), .result(result),
   .result_valid(result_valid), .overrun(overrun)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
   localparam int SETTLE = 40;
   localparam int PULSE  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_req = 1'b0, two_lane = 1'b0, sleep = 1'b0;
   logic [31:0] cfg_word = '0;
   logic [2:0]  adc_convst;
   logic        adc_busy, adc_stby_n, adc_fs, adc_sclk, adc_sdi;
   logic        adc_sdo_a, adc_sdo_b;
   logic [95:0] result;
   logic        result_valid, overrun;

   int checks = 0, errors = 0, cyc = 0;

   always #10 clk = ~clk;

   adc_serial_reader #(.DIV(2), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE)) u_adc_serial_reader (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .two_lane(two_lane),
      .cfg_word(cfg_word), .sleep(sleep), .adc_convst(adc_convst),
      .adc_busy(adc_busy), .adc_stby_n(adc_stby_n), .adc_fs(adc_fs),
      .adc_sclk(adc_sclk), .adc_sdi(adc_sdi), .adc_sdo_a(adc_sdo_a),
      .adc_sdo_b(adc_sdo_b), .result(result), .result_valid(result_valid),
      .overrun(overrun)
   );

   // converter model
   logic        conv_prev = 1'b0, busy_m = 1'b0, lane_m = 1'b0;
   int          bcnt = 0, nconv = 0, nfall = 0, hi_cnt = 0, split_cnt = 0, busy_viol = 0;
   logic [95:0] stra = '0;
   logic [47:0] strb = '0;
   logic [31:0] sdi_cap = '0;
   logic [15:0] chv [6];

   assign adc_busy = busy_m;

   always @(posedge clk) begin
      conv_prev <= adc_convst[0];
      if (adc_convst[0] && !conv_prev) begin
         busy_m <= 1'b1; bcnt <= 20; nconv <= nconv + 1;
      end else if (bcnt > 0) begin
         bcnt <= bcnt - 1;
         if (bcnt == 1) busy_m <= 1'b0;
      end
   end

   always @(negedge adc_sclk or negedge adc_fs) begin
      if (adc_sclk) begin
         nfall = 0; sdi_cap = '0;
      end else if (!adc_fs) begin
         if (nfall < 32) sdi_cap[31-nfall] = adc_sdi;
         nfall = nfall + 1;
      end
   end

   assign adc_sdo_a = lane_m ? ((nfall < 48) ? stra[47-nfall] : 1'b0)
                             : ((nfall < 96) ? stra[95-nfall] : 1'b0);
   assign adc_sdo_b = (lane_m && nfall < 48) ? strb[47-nfall] : 1'b0;

   always @(negedge clk) begin
      if (adc_convst == 3'b111) hi_cnt++;
      if (adc_convst != 3'b000 && adc_convst != 3'b111) split_cnt++;
      if (!adc_fs && busy_m) busy_viol++;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         errors++;
         $display("FAIL watchdog R3 actual %0d expected below 100000 cycles", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_setup(input logic [31:0] w);
      logic [31:0] r = w;
      if (w[11] == 1'b0) r[23] = 1'b0;
      return r;
   endfunction

   function automatic logic [95:0] exp_bus();
      logic [95:0] r;
      for (int k = 0; k < 6; k++) r[k*16 +: 16] = chv[k];
      return r;
   endfunction

   task automatic load_data(input logic lane, input logic [15:0] seed);
      for (int k = 0; k < 6; k++) chv[k] = seed + 16'(k) * 16'h1357 + 16'(k << 12);
      lane_m = lane;
      if (lane) begin
         stra = {48'h0, chv[0], chv[1], chv[4]};
         strb = {chv[2], chv[3], chv[5]};
      end else begin
         stra = {chv[0], chv[1], chv[2], chv[3], chv[4], chv[5]};
         strb = '0;
      end
   endtask

   task automatic pulse_req();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   task automatic wait_valid(output bit got);
      got = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (result_valid) begin got = 1; break; end
      end
   endtask

   // lane mode, setup word, data seed
   localparam logic [48:0] VEC [4] = '{
      {1'b1, 32'h0080_0800, 16'h1234},
      {1'b0, 32'hA5C3_0F96, 16'h8001},
      {1'b0, 32'h0080_0000, 16'hFFFF},
      {1'b1, 32'hFFFF_F7FF, 16'h0F0F}
   };

   initial begin
      bit got;
      int n0;
      repeat (4) @(negedge clk);
      chk("R1 fs/sclk/convst/valid/overrun", {90'h0, adc_fs, adc_sclk, adc_convst, result_valid, overrun},
          {90'h0, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0});
      chk("R1 stby_n awake", {95'h0, adc_stby_n}, 96'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result after reset", result, 96'h0);

      for (int v = 0; v < 4; v++) begin
         two_lane = VEC[v][48];
         cfg_word = VEC[v][47:16];
         load_data(VEC[v][48], VEC[v][15:0]);
         hi_cnt = 0; n0 = nconv;
         pulse_req();
         wait_valid(got);
         chk($sformatf("R3 vector %0d frame completed", v), {95'h0, got}, 96'h1);
         chk($sformatf("R8 R4 R5 vector %0d results", v), result, exp_bus());
         chk($sformatf("%s vector %0d serial clocks", VEC[v][48] ? "R4" : "R5", v),
             96'(nfall), VEC[v][48] ? 96'd48 : 96'd96);
         chk($sformatf("R6 R7 vector %0d setup word", v), {64'h0, sdi_cap}, {64'h0, exp_setup(VEC[v][47:16])});
         chk($sformatf("R2 vector %0d pulse width", v), 96'(hi_cnt), 96'(PULSE));
         chk($sformatf("R2 vector %0d start count", v), 96'(nconv - n0), 96'd1);
         @(negedge clk);
         chk($sformatf("R8 vector %0d single valid", v), {95'h0, result_valid}, 96'h0);
      end
      chk("R2 lines never split", 96'(split_cnt), 96'd0);
      chk("R3 no frame while busy", 96'(busy_viol), 96'd0);
      chk("R9 no overrun yet", {95'h0, overrun}, 96'h0);

      // overrun: request while waiting for busy
      two_lane = 1'b1; cfg_word = 32'h0000_0800;
      load_data(1'b1, 16'h4242);
      n0 = nconv;
      pulse_req();
      repeat (6) @(negedge clk);
      pulse_req();
      chk("R9 overrun set", {95'h0, overrun}, 96'h1);
      wait_valid(got);
      chk("R9 results despite overrun", result, exp_bus());
      repeat (30) @(negedge clk);
      chk("R9 one conversion only", 96'(nconv - n0), 96'd1);
      chk("R9 overrun sticky", {95'h0, overrun}, 96'h1);

      // standby and settling hold-off
      load_data(1'b1, 16'h7777);
      n0 = nconv;
      @(negedge clk) sleep = 1'b1;
      @(negedge clk);
      chk("R10 standby low", {95'h0, adc_stby_n}, 96'h0);
      pulse_req();
      repeat (5) @(negedge clk);
      sleep = 1'b0;
      hi_cnt = 0;
      repeat (10) @(negedge clk);
      pulse_req();
      repeat (23) @(negedge clk);
      chk("R10 no start during settling", 96'(hi_cnt), 96'd0);
      wait_valid(got);
      chk("R10 held request served", result, exp_bus());
      repeat (30) @(negedge clk);
      chk("R10 exactly one conversion", 96'(nconv - n0), 96'd1);

      // reset clears overrun
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 R1 overrun cleared by reset", {94'h0, overrun, result_valid}, 96'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule